// File: doc/BRIEF.md
# Scaler Phase Setup Calculator

This block turns a source rectangle size and a destination rectangle size into the per-axis settings that a polyphase image scaler needs before it starts a frame. For each of the horizontal and vertical axes it produces a rounded initial phase, a phase increment (delta) and the integer part of the upscale ratio. It also raises an edge-enhancement enable when either axis is enlarged by a factor of two or more.

A control processor or a frame-setup sequencer drives the four sizes and a mask of the planes that request scaling, then pulses `start`. Only one plane can be routed through the scaler. An empty mask means scaling is switched off and finishes at once, without any division. A mask with more than one bit set is refused. A zero size is reported as an error rather than producing results. Otherwise the six quotients are produced one after another on a single shared restoring divider, and `done` pulses once the last quotient is stored.

The phase word has 4 phase bits. The delta carries 12 further fractional bits, for 16 fractional bits in total. The upscale ratio is computed in unsigned 16.16 form, and only its integer part is presented.

Top module: `scaler_phase_calc`

## Requirements
- R1: While reset is high and after it is released, every output is zero.
- R2: On a completed calculation, each axis initial phase equals ((src << 4) / dst + 1) / 2, using integer division, with src and dst taken from that same axis.
- R3: On a completed calculation, each axis delta equals (src << 16) / dst, using integer division.
- R4: On a completed calculation, each axis upscale output equals the integer part of (dst << 16) / src, read as an unsigned 16.16 value. This is the same as floor(dst / src).
- R5: On a completed calculation, `enh_en` is 1 exactly when the horizontal or the vertical upscale output is 2 or more.
- R6: If `start` is accepted with `plane_mask` all zero, then in the next cycle `done` is 1 and `scale_en`, `reject`, `div_err`, `enh_en` and every phase and upscale output are 0. This case is checked first.
- R7: If `start` is accepted with more than one bit of `plane_mask` set, then in the next cycle `done` and `reject` are 1, and `scale_en`, `div_err` and all results are 0.
- R8: If `start` is accepted with exactly one mask bit set and any of the four sizes zero, then in the next cycle `done` and `div_err` are 1, and `scale_en`, `reject` and all results are 0.
- R9: A calculation that is carried out ends with `done` high for exactly one cycle, 6*(SZW+18) cycles after the accepting clock edge. In that cycle `scale_en` is 1 and `reject` and `div_err` are 0.
- R10: A `start` that arrives while a calculation is in progress is ignored. The results of the running calculation are unchanged, and no further `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when the block is idle |
| plane_mask | input | PLANES | One bit per plane that asks for scaling |
| src_w | input | SZW | Source width in pixels |
| src_h | input | SZW | Source height in lines |
| dst_w | input | SZW | Destination width in pixels |
| dst_h | input | SZW | Destination height in lines |
| scale_en | output | 1 | Scaling configured and enabled |
| h_init | output | SZW+4 | Horizontal initial phase |
| v_init | output | SZW+4 | Vertical initial phase |
| h_delta | output | SZW+16 | Horizontal phase increment |
| v_delta | output | SZW+16 | Vertical phase increment |
| h_up | output | SZW | Horizontal upscale, integer part |
| v_up | output | SZW | Vertical upscale, integer part |
| enh_en | output | 1 | Edge enhancement enable |
| reject | output | 1 | More than one plane requested |
| div_err | output | 1 | A size of zero was given |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with SZW = 12 and PLANES = 3. This gives a 28-bit dividend, so each full calculation takes 180 cycles, and the widest legal sizes (4095 against 1 and 1 against 4095) can be reached directly. With these values the delta of the largest shrink lands just below the 28-bit limit, and the largest upscale fills the 12-bit integer output. The ratios of exactly 2 and just under 2 test the enhancement threshold. Three mask bits are enough to cover the empty case, the single-plane case and several multi-plane patterns.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned PHASE_BITS = 4;
  localparam int unsigned FRAC_BITS  = 12;
  localparam int unsigned SHIFT_TOTAL = PHASE_BITS + FRAC_BITS;
  // unsigned 16.16 ratio: fractional width equals the delta shift
  localparam int unsigned UP_FRAC = SHIFT_TOTAL;

  typedef enum logic [2:0] {
    OP_H_INIT  = 3'd0,
    OP_H_DELTA = 3'd1,
    OP_H_UP    = 3'd2,
    OP_V_INIT  = 3'd3,
    OP_V_DELTA = 3'd4,
    OP_V_UP    = 3'd5
  } scp_op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } scp_state_e;
endpackage

// File: rtl/scp_operand_sel.sv
module scp_operand_sel
  import scp_pkg::*;
#(
  parameter int unsigned SZW = 16,
  localparam int unsigned NW = SZW + SHIFT_TOTAL
) (
  input  scp_op_e        op,
  input  logic [SZW-1:0] src_w,
  input  logic [SZW-1:0] src_h,
  input  logic [SZW-1:0] dst_w,
  input  logic [SZW-1:0] dst_h,
  output logic [NW-1:0]  num,
  output logic [SZW-1:0] den
);
  logic [SZW-1:0] src_a, dst_a;
  logic           vert;

  assign vert  = (op == OP_V_INIT) || (op == OP_V_DELTA) || (op == OP_V_UP);
  assign src_a = vert ? src_h : src_w;
  assign dst_a = vert ? dst_h : dst_w;

  always_comb begin
    num = '0;
    den = dst_a;
    case (op)
      OP_H_INIT, OP_V_INIT: begin
        num[SZW+PHASE_BITS-1:0] = {src_a, {PHASE_BITS{1'b0}}};
        den = dst_a;
      end
      OP_H_DELTA, OP_V_DELTA: begin
        num = {src_a, {SHIFT_TOTAL{1'b0}}};
        den = dst_a;
      end
      default: begin
        num = {dst_a, {UP_FRAC{1'b0}}};
        den = src_a;
      end
    endcase
  end
endmodule

// File: rtl/scp_restoring_div.sv
module scp_restoring_div #(
  parameter int unsigned NW = 32,
  parameter int unsigned DW = 16,
  localparam int unsigned CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          valid,
  output logic          busy
);
  logic [NW-1:0] work_q;
  logic [DW-1:0] rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial, diff;
  logic          fits;

  assign trial = {rem_q, work_q[NW-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = trial >= {1'b0, den_q};
  assign quo   = work_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (load) begin
        work_q <= num;
        den_q  <= den;
        rem_q  <= '0;
        cnt_q  <= CW'(NW);
        busy   <= 1'b1;
      end else if (busy) begin
        work_q <= {work_q[NW-2:0], fits};
        rem_q  <= fits ? diff[DW-1:0] : trial[DW-1:0];
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc
  import scp_pkg::*;
#(
  parameter int unsigned SZW    = 16,
  parameter int unsigned PLANES = 4,
  localparam int unsigned NW  = SZW + SHIFT_TOTAL,
  localparam int unsigned IPW = SZW + PHASE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PLANES-1:0] plane_mask,
  input  logic [SZW-1:0]    src_w,
  input  logic [SZW-1:0]    src_h,
  input  logic [SZW-1:0]    dst_w,
  input  logic [SZW-1:0]    dst_h,
  output logic              scale_en,
  output logic [IPW-1:0]    h_init,
  output logic [IPW-1:0]    v_init,
  output logic [NW-1:0]     h_delta,
  output logic [NW-1:0]     v_delta,
  output logic [SZW-1:0]    h_up,
  output logic [SZW-1:0]    v_up,
  output logic              enh_en,
  output logic              reject,
  output logic              div_err,
  output logic              done
);
  scp_state_e     state_q;
  scp_op_e        op_q;
  logic [SZW-1:0] sw_q, sh_q, dw_q, dh_q;
  logic [NW-1:0]  div_num, div_quo;
  logic [SZW-1:0] div_den;
  logic           div_valid, div_busy, div_load;
  logic           mask_empty, mask_multi, size_zero, early_exit;
  logic [IPW-1:0] init_val;
  logic [SZW-1:0] up_val;
  logic           calc_busy;

  assign calc_busy  = (state_q != S_IDLE);
  assign mask_empty = (plane_mask == '0);
  assign mask_multi = ((plane_mask & (plane_mask - 1'b1)) != '0);
  assign size_zero  = (src_w == '0) || (src_h == '0) || (dst_w == '0) || (dst_h == '0);
  assign early_exit = mask_empty || mask_multi || size_zero;
  assign div_load   = (state_q == S_ISSUE);

  // ceil(q/2) == (q + 1) / 2 without a wider adder
  assign init_val = IPW'(div_quo[IPW-1:1]) + IPW'(div_quo[0]);
  assign up_val   = div_quo[NW-1:UP_FRAC];

  scp_operand_sel #(.SZW(SZW)) u_sel (
    .op(op_q), .src_w(sw_q), .src_h(sh_q), .dst_w(dw_q), .dst_h(dh_q),
    .num(div_num), .den(div_den)
  );

  scp_restoring_div #(.NW(NW), .DW(SZW)) u_div (
    .clk(clk), .rst(rst), .load(div_load), .num(div_num), .den(div_den),
    .quo(div_quo), .valid(div_valid), .busy(div_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      op_q     <= OP_H_INIT;
      sw_q     <= '0;
      sh_q     <= '0;
      dw_q     <= '0;
      dh_q     <= '0;
      scale_en <= 1'b0;
      h_init   <= '0;
      v_init   <= '0;
      h_delta  <= '0;
      v_delta  <= '0;
      h_up     <= '0;
      v_up     <= '0;
      enh_en   <= 1'b0;
      reject   <= 1'b0;
      div_err  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            sw_q <= src_w;
            sh_q <= src_h;
            dw_q <= dst_w;
            dh_q <= dst_h;
            if (early_exit) begin
              scale_en <= 1'b0;
              h_init   <= '0;
              v_init   <= '0;
              h_delta  <= '0;
              v_delta  <= '0;
              h_up     <= '0;
              v_up     <= '0;
              enh_en   <= 1'b0;
              reject   <= !mask_empty && mask_multi;
              div_err  <= !mask_empty && !mask_multi && size_zero;
              done     <= 1'b1;
            end else begin
              op_q    <= OP_H_INIT;
              state_q <= S_ISSUE;
            end
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (div_valid && !div_busy) begin
            case (op_q)
              OP_H_INIT:  h_init  <= init_val;
              OP_H_DELTA: h_delta <= div_quo;
              OP_H_UP:    h_up    <= up_val;
              OP_V_INIT:  v_init  <= init_val;
              OP_V_DELTA: v_delta <= div_quo;
              default:    v_up    <= up_val;
            endcase
            if (op_q == OP_V_UP) begin
              state_q  <= S_IDLE;
              done     <= 1'b1;
              scale_en <= 1'b1;
              reject   <= 1'b0;
              div_err  <= 1'b0;
              enh_en   <= (h_up >= SZW'(2)) || (up_val >= SZW'(2));
            end else begin
              op_q    <= scp_op_e'(op_q + 3'd1);
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int unsigned SZW    = 16,
  parameter int unsigned PLANES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              calc_busy,
  input logic [PLANES-1:0] plane_mask,
  input logic              scale_en,
  input logic              enh_en,
  input logic              reject,
  input logic              div_err,
  input logic              done,
  input logic [SZW-1:0]    h_up,
  input logic [SZW-1:0]    v_up
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !calc_busy);

  a_r6_empty_skip: assert property (@(posedge clk) disable iff (rst)
    (start && !calc_busy && plane_mask == '0) |=> (done && !scale_en && !reject && !div_err));

  a_r7_multi_reject: assert property (@(posedge clk) disable iff (rst)
    (start && !calc_busy && $countones(plane_mask) > 1) |=> (done && reject && !scale_en));

  a_r8_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    div_err |-> (!scale_en && !reject));

  a_r5_enh_rule: assert property (@(posedge clk) disable iff (rst)
    (done && scale_en) |-> (enh_en == ((h_up >= SZW'(2)) || (v_up >= SZW'(2)))));
endmodule

bind scaler_phase_calc scp_checker #(.SZW(SZW), .PLANES(PLANES)) u_chk (
  .clk(clk), .rst(rst), .start(start), .calc_busy(calc_busy),
  .plane_mask(plane_mask), .scale_en(scale_en), .enh_en(enh_en),
  .reject(reject), .div_err(div_err), .done(done), .h_up(h_up), .v_up(v_up)
);

// File: tb/sim_scaler_phase_calc.sv
module sim_scaler_phase_calc;
  localparam int unsigned SZW = 12;
  localparam int unsigned PLANES = 3;
  localparam int unsigned NW = SZW + 16;
  localparam int unsigned IPW = SZW + 4;
  localparam int LATENCY = 6 * (NW + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [PLANES-1:0] plane_mask = '0;
  logic [SZW-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic scale_en, enh_en, reject, div_err, done;
  logic [IPW-1:0] h_init, v_init;
  logic [NW-1:0] h_delta, v_delta;
  logic [SZW-1:0] h_up, v_up;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scaler_phase_calc #(.SZW(SZW), .PLANES(PLANES)) u0 (
    .clk(clk), .rst(rst), .start(start), .plane_mask(plane_mask),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .scale_en(scale_en), .h_init(h_init), .v_init(v_init),
    .h_delta(h_delta), .v_delta(v_delta), .h_up(h_up), .v_up(v_up),
    .enh_en(enh_en), .reject(reject), .div_err(div_err), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint e_init(longint s, longint d);
    return ((s * 16) / d + 1) / 2;
  endfunction
  function automatic longint e_delta(longint s, longint d);
    return (s * 65536) / d;
  endfunction
  function automatic longint e_up(longint s, longint d);
    return ((d * 65536) / s) / 65536;
  endfunction

  task automatic pulse_start(input logic [PLANES-1:0] m, input int sw, input int sh,
                             input int dw, input int dh);
    @(negedge clk);
    plane_mask = m;
    src_w = SZW'(sw); src_h = SZW'(sh); dst_w = SZW'(dw); dst_h = SZW'(dh);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_all_zero(input string req);
    chk({req, " h_init"}, h_init, 0);
    chk({req, " v_init"}, v_init, 0);
    chk({req, " h_delta"}, h_delta, 0);
    chk({req, " v_delta"}, v_delta, 0);
    chk({req, " h_up"}, h_up, 0);
    chk({req, " v_up"}, v_up, 0);
    chk({req, " enh_en"}, enh_en, 0);
  endtask

  task automatic test_reset();
    chk("R1 scale_en", scale_en, 0);
    chk("R1 reject", reject, 0);
    chk("R1 div_err", div_err, 0);
    chk("R1 done", done, 0);
    check_all_zero("R1");
  endtask

  task automatic test_compute(input logic [PLANES-1:0] m, input int sw, input int sh,
                              input int dw, input int dh);
    int cyc;
    longint hu, vu;
    pulse_start(m, sw, sh, dw, dh);
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 latency", cyc, LATENCY);
    hu = e_up(sw, dw);
    vu = e_up(sh, dh);
    chk("R2 h_init", h_init, e_init(sw, dw));
    chk("R2 v_init", v_init, e_init(sh, dh));
    chk("R3 h_delta", h_delta, e_delta(sw, dw));
    chk("R3 v_delta", v_delta, e_delta(sh, dh));
    chk("R4 h_up", h_up, hu);
    chk("R4 v_up", v_up, vu);
    chk("R5 enh_en", enh_en, (hu >= 2 || vu >= 2) ? 1 : 0);
    chk("R9 scale_en", scale_en, 1);
    chk("R9 reject", reject, 0);
    chk("R9 div_err", div_err, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic test_early(input string req, input logic [PLANES-1:0] m, input int sw,
                            input int sh, input int dw, input int dh,
                            input int exp_rej, input int exp_err);
    pulse_start(m, sw, sh, dw, dh);
    chk({req, " done"}, done, 1);
    chk({req, " scale_en"}, scale_en, 0);
    chk({req, " reject"}, reject, exp_rej);
    chk({req, " div_err"}, div_err, exp_err);
    check_all_zero(req);
    @(negedge clk);
    chk({req, " done one cycle"}, done, 0);
  endtask

  task automatic test_busy_ignore();
    int cyc;
    int extra;
    pulse_start(3'b010, 200, 90, 50, 270);
    repeat (20) @(negedge clk);
    start = 1'b1;
    plane_mask = 3'b001;
    src_w = SZW'(7); src_h = SZW'(9); dst_w = SZW'(900); dst_h = SZW'(11);
    @(negedge clk);
    start = 1'b0;
    cyc = 21;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10 latency kept", cyc, LATENCY);
    chk("R10 h_init", h_init, e_init(200, 50));
    chk("R10 v_delta", v_delta, e_delta(90, 270));
    chk("R10 h_up", h_up, e_up(200, 50));
    chk("R10 v_up", v_up, e_up(90, 270));
    extra = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10 no second done", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_compute(3'b001, 100, 50, 300, 200);
    test_compute(3'b100, 400, 300, 200, 300);
    test_compute(3'b010, 10, 15, 20, 15);
    test_compute(3'b001, 10, 10, 19, 19);
    test_compute(3'b100, 4095, 4095, 1, 1);
    test_compute(3'b010, 1, 1, 4095, 4095);
    test_early("R6 empty", 3'b000, 100, 50, 300, 200, 0, 0);
    test_early("R6 empty with zero size", 3'b000, 0, 0, 0, 0, 0, 0);
    test_compute(3'b001, 64, 48, 64, 48);
    test_early("R7 two planes", 3'b011, 100, 50, 300, 200, 1, 0);
    test_early("R7 all planes", 3'b111, 0, 50, 300, 200, 1, 0);
    test_early("R8 dst_w zero", 3'b010, 100, 50, 0, 200, 0, 1);
    test_early("R8 src_h zero", 3'b001, 100, 0, 300, 200, 0, 1);
    test_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule